// File: doc/BRIEF.md
# Three-slot decode steering with micro-op sequencer

This block sits between an in-order queue of pre-decoded instructions and a downstream micro-op buffer. Each cycle it looks at the oldest three queue entries. Every entry carries a micro-op count, a read-modify-write memory flag and a tag. The block assigns the entries to three decode slots that are not equal. Slot 0 is the general slot and takes any instruction, emitting up to four micro-ops at once. Slots 1 and 2 take only instructions that reduce to a single micro-op. An instruction that needs more than four micro-ops goes to a sequencer, which emits its micro-ops four at a time over consecutive cycles.

The micro-ops leave on six output lanes. Lanes 0 to 3 belong to slot 0 or to the sequencer, lane 4 to slot 1 and lane 5 to slot 2. Each valid lane carries the instruction tag and the index of the micro-op within its instruction. The block reports how many queue entries it consumed in the cycle. It never emits more micro-ops than the downstream buffer reports as free. A synchronous flush discards the cycle's work and aborts the sequencer.

Top module: `decsteer_top`

## Requirements
- R1: After reset no lane is valid, no entry is consumed and the sequencer is idle.
- R2: An entry's effective micro-op count is its count field, with 0 read as 1. When the memory flag is 1 the count is raised to at least 3. An entry with an effective count of 1 is simple.
- R3: When the sequencer is idle, entry 0 is valid and its effective count n is at most 4, entry 0 is consumed. It emits on lanes 0 to n-1 with indices 0 to n-1 and its own tag.
- R4: After entry 0, entries 1 and 2 are taken in order onto lanes 4 and 5 while each is valid and simple. A simple entry behind an invalid or non-simple one is not taken. At most three entries are consumed per cycle.
- R5: A non-simple entry that is not entry 0 ends allocation for that cycle. When the queue presents it as entry 0 in the next cycle, it is decoded in slot 0.
- R6: An entry 0 with an effective count n greater than 4 is consumed and emits indices 0 to 3 on lanes 0 to 3. In each following cycle the sequencer emits the next min(4, remaining) micro-ops on lanes 0 upward, with the same tag and continuing indices. No entry is consumed until its last micro-op has been emitted.
- R7: If the cycle's micro-ops outnumber the free count on dn_free, no lane is valid, nothing is consumed and the sequencer state holds.
- R8: While flush is 1, no lane is valid and nothing is consumed. The sequencer is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard this cycle and abort the sequencer |
| in_valid | input | 3 | Valid bit per queue entry, bit 0 oldest |
| in_uops | input | 3x4 | Micro-op count per entry |
| in_rmw | input | 3 | Entry has a memory operand that is read and written |
| in_tag | input | 3x6 | Tag per entry |
| in_take | output | 2 | Number of entries consumed this cycle |
| dn_free | input | 4 | Free entries in the downstream buffer |
| out_valid | output | 6 | Valid bit per micro-op lane |
| out_tag | output | 6x6 | Tag per lane |
| out_idx | output | 6x4 | Micro-op index within the instruction, per lane |

## Verification
On every cycle the assertions check the following. The number of valid lanes never exceeds dn_free. Lane 0 leads every emission, and the simple lanes fill in order. Nothing is consumed while the sequencer is busy. A flush silences the outputs and leaves the sequencer idle. The sequencer's tag holds while it is busy. Only the bench scenarios can show the exact lane patterns and indices. This covers the stop when a complex instruction is not first and its decode in the following cycle, the count rules for the zero count and the memory flag, and the sequencer's index progression over several cycles. It also covers a stall that holds the sequencer mid-instruction and resumes it, and a flush that drops an unfinished long instruction.

// File: rtl/decsteer_pkg.sv
package decsteer_pkg;

   // Class of a queue entry once its effective micro-op count is known
   typedef enum logic [1:0] {
      K_SIMPLE = 2'd0,   // exactly one micro-op
      K_MULTI  = 2'd1,   // fits in the general slot in one cycle
      K_LONG   = 2'd2    // needs the sequencer
   } ikind_e;

endpackage

// File: rtl/decsteer_classify.sv
module decsteer_classify #(
   parameter int UOP_W    = 4,
   parameter int GEN_UOPS = 4,
   parameter int RMW_MIN  = 3
) (
   input  logic [UOP_W-1:0]     uops_i,
   input  logic                 rmw_i,
   output logic [UOP_W-1:0]     eff_o,
   output decsteer_pkg::ikind_e kind_o
);
   import decsteer_pkg::*;

   localparam logic [UOP_W-1:0] ONE  = UOP_W'(1);
   localparam logic [UOP_W-1:0] RMIN = UOP_W'(RMW_MIN);
   localparam logic [UOP_W-1:0] GMAX = UOP_W'(GEN_UOPS);

   logic [UOP_W-1:0] base;

   always_comb begin
      base = (uops_i == '0) ? ONE : uops_i;   // R2 zero reads as one
      eff_o = (rmw_i && base < RMIN) ? RMIN : base;
      if (eff_o == ONE)       kind_o = K_SIMPLE;
      else if (eff_o <= GMAX) kind_o = K_MULTI;
      else                    kind_o = K_LONG;
   end

endmodule

// File: rtl/decsteer_alloc.sv
module decsteer_alloc #(
   parameter int NIN   = 3,
   parameter int UOP_W = 4,
   parameter int GEN_UOPS = 4,
   localparam int CNT_W  = UOP_W + 1,
   localparam int TAKE_W = $clog2(NIN + 1)
) (
   input  logic                 seq_busy_i,
   input  logic [NIN-1:0]       valid_i,
   input  decsteer_pkg::ikind_e kind_i [NIN],
   input  logic [UOP_W-1:0]     eff0_i,
   output logic [NIN-1:0]       take_o,
   output logic                 start_long_o,
   output logic [CNT_W-1:0]     need_o,
   output logic [TAKE_W-1:0]    count_o
);
   import decsteer_pkg::*;

   logic chain;

   always_comb begin
      take_o       = '0;
      start_long_o = 1'b0;
      need_o       = '0;
      count_o      = '0;
      chain        = 1'b0;
      if (!seq_busy_i && valid_i[0]) begin
         take_o[0] = 1'b1;
         count_o   = TAKE_W'(1);
         if (kind_i[0] == K_LONG) begin
            start_long_o = 1'b1;          // R6 first burst fills slot 0
            need_o       = CNT_W'(GEN_UOPS);
         end else begin
            need_o = CNT_W'(eff0_i);      // R3
            chain  = 1'b1;
         end
         for (int k = 1; k < NIN; k++) begin
            chain     = chain && valid_i[k] && (kind_i[k] == K_SIMPLE); // R4 R5
            take_o[k] = chain;
            if (chain) begin
               need_o  = need_o + CNT_W'(1);
               count_o = count_o + TAKE_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/decsteer_seq.sv
module decsteer_seq #(
   parameter int TAG_W    = 6,
   parameter int UOP_W    = 4,
   parameter int GEN_UOPS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             fire_i,
   input  logic             start_i,
   input  logic [TAG_W-1:0] start_tag_i,
   input  logic [UOP_W-1:0] start_eff_i,
   output logic             busy_o,
   output logic [TAG_W-1:0] tag_o,
   output logic [UOP_W-1:0] emit_o,
   output logic [UOP_W-1:0] idx_o
);
   localparam logic [UOP_W-1:0] GMAX = UOP_W'(GEN_UOPS);

   logic             busy_q;
   logic [TAG_W-1:0] tag_q;
   logic [UOP_W-1:0] rem_q;
   logic [UOP_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tag_q  <= '0;
         rem_q  <= '0;
         idx_q  <= '0;
      end else if (flush_i) begin
         busy_q <= 1'b0;
      end else if (fire_i) begin
         if (busy_q) begin
            if (rem_q <= GMAX) begin
               busy_q <= 1'b0;
            end else begin
               rem_q <= rem_q - GMAX;
               idx_q <= idx_q + GMAX;
            end
         end else if (start_i) begin
            busy_q <= 1'b1;
            tag_q  <= start_tag_i;
            rem_q  <= start_eff_i - GMAX;
            idx_q  <= GMAX;
         end
      end
   end

   assign busy_o = busy_q;
   assign tag_o  = tag_q;
   assign idx_o  = idx_q;
   assign emit_o = (rem_q <= GMAX) ? rem_q : GMAX;

   AST_SEQ_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_q) && busy_q |-> $stable(tag_q)); // R6

   AST_FLUSH_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !busy_q); // R8

endmodule

// File: rtl/decsteer_top.sv
module decsteer_top #(
   parameter int TAG_W    = 6,
   parameter int UOP_W    = 4,
   parameter int GEN_UOPS = 4,
   parameter int NSIMPLE  = 2,
   parameter int FREE_W   = 4,
   parameter int RMW_MIN  = 3,
   localparam int NIN    = 1 + NSIMPLE,
   localparam int NLANE  = GEN_UOPS + NSIMPLE,
   localparam int TAKE_W = $clog2(NIN + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic [NIN-1:0]              in_valid,
   input  logic [NIN-1:0][UOP_W-1:0]   in_uops,
   input  logic [NIN-1:0]              in_rmw,
   input  logic [NIN-1:0][TAG_W-1:0]   in_tag,
   output logic [TAKE_W-1:0]           in_take,
   input  logic [FREE_W-1:0]           dn_free,
   output logic [NLANE-1:0]            out_valid,
   output logic [NLANE-1:0][TAG_W-1:0] out_tag,
   output logic [NLANE-1:0][UOP_W-1:0] out_idx
);
   import decsteer_pkg::*;

   localparam int CNT_W = UOP_W + 1;
   localparam int CMP_W = (CNT_W > FREE_W) ? CNT_W : FREE_W;

   if (GEN_UOPS < 2) begin : g_chk_gen
      $error("GEN_UOPS must be at least 2");
   end
   if ((1 << UOP_W) - 1 <= GEN_UOPS) begin : g_chk_uopw
      $error("UOP_W too narrow for counts beyond GEN_UOPS");
   end
   if (RMW_MIN > GEN_UOPS || RMW_MIN < 2) begin : g_chk_rmw
      $error("RMW_MIN must lie in 2..GEN_UOPS");
   end

   logic [UOP_W-1:0] eff  [NIN];
   ikind_e           kind [NIN];

   for (genvar k = 0; k < NIN; k++) begin : g_cls
      decsteer_classify #(
         .UOP_W(UOP_W), .GEN_UOPS(GEN_UOPS), .RMW_MIN(RMW_MIN)
      ) cls_i (
         .uops_i(in_uops[k]), .rmw_i(in_rmw[k]),
         .eff_o(eff[k]), .kind_o(kind[k])
      );
   end

   logic             seq_busy;
   logic [TAG_W-1:0] seq_tag;
   logic [UOP_W-1:0] seq_emit;
   logic [UOP_W-1:0] seq_idx;

   logic [NIN-1:0]    take;
   logic              start_long;
   logic [CNT_W-1:0]  alloc_need;
   logic [TAKE_W-1:0] alloc_count;

   decsteer_alloc #(.NIN(NIN), .UOP_W(UOP_W), .GEN_UOPS(GEN_UOPS)) alloc_i (
      .seq_busy_i(seq_busy), .valid_i(in_valid), .kind_i(kind),
      .eff0_i(eff[0]), .take_o(take), .start_long_o(start_long),
      .need_o(alloc_need), .count_o(alloc_count)
   );

   logic [CNT_W-1:0] need;
   logic             fire;

   assign need = seq_busy ? CNT_W'(seq_emit) : alloc_need;
   assign fire = !flush && (CMP_W'(need) <= CMP_W'(dn_free));  // R7 R8

   decsteer_seq #(.TAG_W(TAG_W), .UOP_W(UOP_W), .GEN_UOPS(GEN_UOPS)) seq_i (
      .clk(clk), .rst_n(rst_n), .flush_i(flush), .fire_i(fire),
      .start_i(start_long), .start_tag_i(in_tag[0]), .start_eff_i(eff[0]),
      .busy_o(seq_busy), .tag_o(seq_tag), .emit_o(seq_emit), .idx_o(seq_idx)
   );

   assign in_take = fire ? alloc_count : '0;

   // General slot lanes, shared by slot 0 and the sequencer
   for (genvar l = 0; l < GEN_UOPS; l++) begin : g_gen_lane
      always_comb begin
         if (seq_busy) begin
            out_valid[l] = fire && (UOP_W'(l) < seq_emit);
            out_tag[l]   = seq_tag;
            out_idx[l]   = seq_idx + UOP_W'(l);
         end else begin
            out_valid[l] = fire && take[0] && (start_long || UOP_W'(l) < eff[0]);
            out_tag[l]   = in_tag[0];
            out_idx[l]   = UOP_W'(l);
         end
      end
      if (l > 0) begin : g_lead
         AST_LANE0_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[l] |-> out_valid[0]); // R3
      end
   end

   // Simple slot lanes
   for (genvar k = 1; k < NIN; k++) begin : g_simple_lane
      localparam int LN = GEN_UOPS + k - 1;
      assign out_valid[LN] = fire && take[k];
      assign out_tag[LN]   = in_tag[k];
      assign out_idx[LN]   = '0;
      if (k > 1) begin : g_ord
         AST_SIMPLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[LN] |-> out_valid[LN-1]); // R4
      end else begin : g_first
         AST_SIMPLE_AFTER_GEN: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[LN] |-> out_valid[0] && !seq_busy); // R4
      end
   end

   AST_FREE_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      CMP_W'($countones(out_valid)) <= CMP_W'(dn_free)); // R7

   AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> out_valid == '0 && in_take == '0); // R8

   AST_SEQ_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_busy |-> in_take == '0); // R6

   AST_TAKE_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
      in_take != '0 |-> out_valid[0]); // R3

endmodule

// File: tb/decsteer_top_tb_top.sv
module decsteer_top_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic [2:0]      in_valid = '0;
   logic [2:0][3:0] in_uops = '0;
   logic [2:0]      in_rmw = '0;
   logic [2:0][5:0] in_tag = '0;
   logic [1:0]      in_take;
   logic [3:0]      dn_free = 4'd15;
   logic [5:0]      out_valid;
   logic [5:0][5:0] out_tag;
   logic [5:0][3:0] out_idx;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   decsteer_top dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_uops(in_uops), .in_rmw(in_rmw), .in_tag(in_tag),
      .in_take(in_take), .dn_free(dn_free),
      .out_valid(out_valid), .out_tag(out_tag), .out_idx(out_idx)
   );

   task automatic chk(input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", what, got, exp);
      end
   endtask

   task automatic ent(input int k, input bit v, input int uops, input bit rmw, input int tag);
      in_valid[k] = v;
      in_uops[k]  = 4'(uops);
      in_rmw[k]   = rmw;
      in_tag[k]   = 6'(tag);
   endtask

   // move to the next cycle's drive point, then let outputs settle
   task automatic step();
      @(negedge clk);
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic t_reset();
      in_valid = '0;
      rst_n = 1'b0;
      repeat (3) step();
      settle();
      chk("R1 valid in reset", out_valid, 0);
      chk("R1 take in reset", in_take, 0);
      rst_n = 1'b1;
      step(); settle();
      chk("R1 valid after reset", out_valid, 0);
      chk("R1 take after reset", in_take, 0);
   endtask

   task automatic t_three_simple();
      step();
      ent(0,1,1,0,1); ent(1,1,1,0,2); ent(2,1,1,0,3);
      settle();
      chk("R4 three simple valid", out_valid, 6'b110001);
      chk("R4 three simple take", in_take, 3);
      chk("R3 lane0 tag", out_tag[0], 1);
      chk("R4 lane4 tag", out_tag[4], 2);
      chk("R4 lane5 tag", out_tag[5], 3);
   endtask

   task automatic t_multi_first();
      step();
      ent(0,1,3,0,5); ent(1,1,1,0,6); ent(2,1,1,0,7);
      settle();
      chk("R3 multi first valid", out_valid, 6'b110111);
      chk("R3 multi first take", in_take, 3);
      chk("R3 lane2 idx", out_idx[2], 2);
      chk("R3 lane1 tag", out_tag[1], 5);
   endtask

   task automatic t_complex_second();
      step();
      ent(0,1,1,0,8); ent(1,1,2,0,9); ent(2,1,1,0,10);
      settle();
      chk("R5 stop valid", out_valid, 6'b000001);
      chk("R5 stop take", in_take, 1);
      step();
      ent(0,1,2,0,9); ent(1,1,1,0,10); ent(2,1,0,0,11);
      settle();
      chk("R5 next cycle valid", out_valid, 6'b110011);
      chk("R5 next cycle take", in_take, 3);
      chk("R2 zero count lane5 tag", out_tag[5], 11);
      chk("R5 lane1 tag", out_tag[1], 9);
   endtask

   task automatic t_rmw();
      step();
      ent(0,1,1,0,12); ent(1,1,1,1,13); ent(2,1,1,0,14);
      settle();
      chk("R2 rmw not simple take", in_take, 1);
      chk("R2 rmw not simple valid", out_valid, 6'b000001);
      step();
      ent(0,1,1,1,13); ent(1,1,1,0,14); ent(2,0,1,0,0);
      settle();
      chk("R2 rmw three uops valid", out_valid, 6'b010111);
      chk("R2 rmw three uops take", in_take, 2);
      step();
      ent(0,1,4,1,15); ent(1,0,1,0,0); ent(2,0,1,0,0);
      settle();
      chk("R2 rmw keeps four valid", out_valid, 6'b001111);
      chk("R2 rmw keeps four take", in_take, 1);
   endtask

   task automatic t_gap();
      step();
      ent(0,1,1,0,16); ent(1,0,1,0,0); ent(2,1,1,0,17);
      settle();
      chk("R4 gap take", in_take, 1);
      chk("R4 gap valid", out_valid, 6'b000001);
   endtask

   task automatic t_long();
      step();
      ent(0,1,10,0,20); ent(1,1,1,0,21); ent(2,1,1,0,22);
      settle();
      chk("R6 start valid", out_valid, 6'b001111);
      chk("R6 start take", in_take, 1);
      chk("R6 start idx3", out_idx[3], 3);
      chk("R6 start tag", out_tag[0], 20);
      step();
      ent(0,1,1,0,21); ent(1,1,1,0,22); ent(2,1,1,0,23);
      settle();
      chk("R6 burst2 valid", out_valid, 6'b001111);
      chk("R6 burst2 take", in_take, 0);
      chk("R6 burst2 tag", out_tag[2], 20);
      chk("R6 burst2 idx0", out_idx[0], 4);
      step(); settle();
      chk("R6 last valid", out_valid, 6'b000011);
      chk("R6 last take", in_take, 0);
      chk("R6 last idx1", out_idx[1], 9);
      step(); settle();
      chk("R6 resume valid", out_valid, 6'b110001);
      chk("R6 resume take", in_take, 3);
      chk("R6 resume tag", out_tag[0], 21);
   endtask

   task automatic t_long_exact();
      step();
      ent(0,1,8,0,24); ent(1,0,1,0,0); ent(2,0,1,0,0);
      settle();
      chk("R6 exact start valid", out_valid, 6'b001111);
      chk("R6 exact start take", in_take, 1);
      step();
      ent(0,1,1,0,25);
      settle();
      chk("R6 exact end valid", out_valid, 6'b001111);
      chk("R6 exact end idx3", out_idx[3], 7);
      chk("R6 exact end take", in_take, 0);
      step(); settle();
      chk("R6 exact after valid", out_valid, 6'b000001);
      chk("R6 exact after take", in_take, 1);
   endtask

   task automatic t_backpressure();
      step();
      dn_free = 4'd2;
      ent(0,1,1,0,26); ent(1,1,1,0,27); ent(2,1,1,0,28);
      settle();
      chk("R7 short free valid", out_valid, 0);
      chk("R7 short free take", in_take, 0);
      step();
      dn_free = 4'd3;
      settle();
      chk("R7 exact free valid", out_valid, 6'b110001);
      chk("R7 exact free take", in_take, 3);
      step();
      ent(0,1,6,0,29); ent(1,0,1,0,0); ent(2,0,1,0,0);
      settle();
      chk("R7 long start held", out_valid, 0);
      chk("R7 long start take", in_take, 0);
      step();
      dn_free = 4'd4;
      settle();
      chk("R7 long start valid", out_valid, 6'b001111);
      chk("R7 long start take ok", in_take, 1);
      step();
      in_valid = '0;
      dn_free = 4'd1;
      settle();
      chk("R7 seq stalled valid", out_valid, 0);
      step();
      dn_free = 4'd2;
      settle();
      chk("R7 seq resumed valid", out_valid, 6'b000011);
      chk("R7 seq resumed idx0", out_idx[0], 4);
      chk("R7 seq resumed tag", out_tag[1], 29);
      step();
      dn_free = 4'd15;
      ent(0,1,1,0,30);
      settle();
      chk("R7 seq done take", in_take, 1);
   endtask

   task automatic t_flush();
      step();
      ent(0,1,12,0,31); ent(1,0,1,0,0); ent(2,0,1,0,0);
      settle();
      chk("R8 long start valid", out_valid, 6'b001111);
      step();
      flush = 1'b1;
      settle();
      chk("R8 flush valid", out_valid, 0);
      chk("R8 flush take", in_take, 0);
      step();
      flush = 1'b0;
      ent(0,1,1,0,32);
      settle();
      chk("R8 after flush valid", out_valid, 6'b000001);
      chk("R8 after flush take", in_take, 1);
      chk("R8 after flush tag", out_tag[0], 32);
      step();
      flush = 1'b1;
      ent(0,1,1,0,33); ent(1,1,1,0,34); ent(2,1,1,0,35);
      settle();
      chk("R8 idle flush valid", out_valid, 0);
      chk("R8 idle flush take", in_take, 0);
      step();
      flush = 1'b0;
      in_valid = '0;
   endtask

   initial begin
      t_reset();
      t_three_simple();
      t_multi_first();
      t_complex_second();
      t_rmw();
      t_gap();
      t_long();
      t_long_exact();
      t_backpressure();
      t_flush();
      step();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule